// File: doc/BRIEF.md
# Port-Indexed Jump Sequencer

This block carries out a two-byte prefixed jump (opcode bytes 0xED then 0x98) once the decoder has recognised it. The jump is unconditional. The destination is not held in the instruction. It comes from one byte read over the I/O bus, using the BC register pair as the port address. That byte picks one of 256 entry points, spaced 64 bytes apart, inside the 16 KB quarter of the address space that holds the following instruction.

The decoder pulses `start`, which latches the instruction's own address and the port address. The sequencer then raises an I/O read request and holds it until the port answers with `ioReady`. It builds the target from the advanced program counter (instruction address plus two) and the returned byte. Finally it pulses `pcLoad` and `done` together for one cycle, with the new value on `pcOut`.

Top module: `io_jump_seq`

## Requirements
- R1: While `rstN` is low at a clock edge, `ioReq`, `pcLoad` and `done` are low in the following cycle.
- R2: A `start` sampled while the block is idle raises `ioReq` in the next cycle, and `ioAddr` then carries the `portSel` value that was sampled with that `start`.
- R3: `ioReq` stays high, and `ioAddr` stays unchanged, until an edge at which `ioReady` is sampled high.
- R4: The loaded value equals ((instruction address + 2) AND 0xC000) + (returned byte × 64). Bits 5:0 of the loaded value are always zero.
- R5: An instruction at 0xBFFF with a returned byte of 0x00 loads 0xC000, because its next address 0xC001 already lies in the upper quarter.
- R6: The next-address addition wraps at 16 bits. An instruction at 0xFFFF has a base of 0x0000, and one at 0xFFFD gives targets from 0xC000 to 0xFFC0.
- R7: In the cycle after the edge that samples `ioReq` and `ioReady` both high, `pcLoad` and `done` are high for exactly one cycle.
- R8: A `start` sampled while a jump is in progress has no effect: the port address and the target still follow the values latched at the first `start`.
- R9: Each jump makes exactly one I/O read: `ioReq` is low while `pcLoad` is high, and it stays low until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Jump instruction recognised |
| instrAddr | input | 16 | Address of the instruction's first byte |
| portSel | input | 16 | BC pair, used as the I/O port address |
| ioReq | output | 1 | I/O read request |
| ioAddr | output | 16 | I/O port address |
| ioData | input | 8 | Byte returned by the port |
| ioReady | input | 1 | Port has returned data |
| pcOut | output | 16 | New program counter value |
| pcLoad | output | 1 | Load strobe for the program counter |
| done | output | 1 | Instruction finished |

## Verification
The bound checker watches the handshake on every cycle. It checks that the request is held and the port address stays stable while the port is waiting, that an accepted answer is followed by a single load pulse, that no request is active during the load, that an idle start raises the request, and that the low six bits of the loaded value are zero. Other behaviours need the bench's scenarios, run against its reference model: the exact target arithmetic for every port byte at each quarter boundary, the 16-bit wrap, the case where the next address has crossed into the next quarter, and the rejection of a start that arrives mid-jump.

// File: rtl/io_jump_pkg.sv
package io_jump_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_IO_REQ  = 2'd1,
    ST_IO_WAIT = 2'd2,
    ST_LOAD_PC = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capCmd;   // latch instruction address and port address
    logic capData;  // latch target built from the returned byte
  } dpCtrl_t;
endpackage

// File: rtl/io_jump_ctrl.sv
module io_jump_ctrl
  import io_jump_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    ioReady,
  output dpCtrl_t ctl,
  output logic    ioReq,
  output logic    pcLoad,
  output logic    done
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (start) stateNext = ST_IO_REQ;
      ST_IO_REQ:  stateNext = ioReady ? ST_LOAD_PC : ST_IO_WAIT;
      ST_IO_WAIT: if (ioReady) stateNext = ST_LOAD_PC;
      ST_LOAD_PC: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  logic reqPhase;
  assign reqPhase    = (state == ST_IO_REQ) || (state == ST_IO_WAIT);
  assign ioReq       = reqPhase;
  assign pcLoad      = (state == ST_LOAD_PC);
  assign done        = (state == ST_LOAD_PC);
  assign ctl.capCmd  = (state == ST_IDLE) && start;
  assign ctl.capData = reqPhase && ioReady;
endmodule

// File: rtl/io_jump_dp.sv
module io_jump_dp
  import io_jump_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PORT_W    = 16,
  parameter int KEEP_BITS = 2,
  parameter int SHIFT     = 6,
  parameter int INSTR_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [PORT_W-1:0] portSel,
  input  logic [DATA_W-1:0] ioData,
  output logic [PORT_W-1:0] ioAddr,
  output logic [ADDR_W-1:0] pcOut
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~({ADDR_W{1'b1}} >> KEEP_BITS);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(INSTR_LEN);

  logic [ADDR_W-1:0] addrQ, targetQ;
  logic [PORT_W-1:0] portQ;
  logic [ADDR_W-1:0] nextPc, basePc, offset, targetD;

  // wraps modulo 2**ADDR_W
  assign nextPc  = addrQ + STEP;
  assign basePc  = nextPc & BASE_MASK;
  assign offset  = ADDR_W'(ioData) << SHIFT;
  assign targetD = basePc + offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      portQ   <= '0;
      targetQ <= '0;
    end else begin
      if (ctl.capCmd) begin
        addrQ <= instrAddr;
        portQ <= portSel;
      end
      if (ctl.capData) targetQ <= targetD;
    end
  end

  assign ioAddr = portQ;
  assign pcOut  = targetQ;
endmodule

// File: rtl/io_jump_seq.sv
module io_jump_seq
  import io_jump_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PORT_W    = 16,
  parameter int KEEP_BITS = 2,
  parameter int SHIFT     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [PORT_W-1:0] portSel,
  output logic              ioReq,
  output logic [PORT_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioReady,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcLoad,
  output logic              done
);
  dpCtrl_t ctl;

  io_jump_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ioReady(ioReady),
    .ctl(ctl), .ioReq(ioReq), .pcLoad(pcLoad), .done(done)
  );

  io_jump_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
    .KEEP_BITS(KEEP_BITS), .SHIFT(SHIFT), .INSTR_LEN(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .instrAddr(instrAddr),
    .portSel(portSel), .ioData(ioData), .ioAddr(ioAddr), .pcOut(pcOut)
  );
endmodule

// File: rtl/io_jump_chk.sv
module io_jump_chk #(
  parameter int PORT_W = 16,
  parameter int SHIFT  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              ioReq,
  input logic [PORT_W-1:0] ioAddr,
  input logic              ioReady,
  input logic [SHIFT-1:0]  pcLow,
  input logic              pcLoad,
  input logic              done
);
  p_start_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !ioReq && !pcLoad) |=> ioReq);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && !ioReady) |=> ioReq);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && !ioReady) |=> $stable(ioAddr));

  p_low_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (pcLow == '0));

  p_ready_loads_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && ioReady) |=> (pcLoad && done));

  p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> (!pcLoad && !done));

  p_single_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> !ioReq);
endmodule

bind io_jump_seq io_jump_chk #(.PORT_W(PORT_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .ioReq(ioReq), .ioAddr(ioAddr),
  .ioReady(ioReady), .pcLow(pcOut[SHIFT-1:0]), .pcLoad(pcLoad), .done(done)
);

// File: tb/io_jump_seq_tb.sv
module io_jump_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0, start = 1'b0, ioReady = 1'b0;
  logic [15:0] instrAddr = '0, portSel = '0;
  logic [7:0]  ioData = '0;
  logic        ioReq, pcLoad, done;
  logic [15:0] ioAddr, pcOut;

  io_jump_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instrAddr(instrAddr),
    .portSel(portSel), .ioReq(ioReq), .ioAddr(ioAddr), .ioData(ioData),
    .ioReady(ioReady), .pcOut(pcOut), .pcLoad(pcLoad), .done(done)
  );

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // port responder: answers after waitLimit cycles of request
  int          waitLimit = 0, reqAge = 0;
  logic [7:0]  respByte = '0;
  always @(negedge clk) begin
    if (ioReq) begin
      if (reqAge >= waitLimit) begin ioReady <= 1'b1; ioData <= respByte; end
      reqAge <= reqAge + 1;
    end else begin
      ioReady <= 1'b0;
      reqAge  <= 0;
    end
  end

  // behavioural reference: 0 idle, 1 reading, 2 loading
  int mPhase = 0, mAddr = 0, mPort = 0, mTarget = 0;
  always @(posedge clk) begin
    if (!rstN) mPhase = 0;
    else if (mPhase == 0) begin
      if (start) begin mAddr = int'(instrAddr); mPort = int'(portSel); mPhase = 1; end
    end else if (mPhase == 1) begin
      if (ioReady) begin
        mTarget = (((mAddr + 2) % 65536) & 'hC000) + int'(ioData) * 64;
        mPhase = 2;
      end
    end else mPhase = 0;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      check(!ioReq && !pcLoad && !done, "R1 reset outputs", {ioReq, pcLoad, done}, 0);
    end else begin
      check(ioReq == (mPhase == 1), "R2/R9 ioReq", ioReq, mPhase == 1);
      check(pcLoad == (mPhase == 2), "R7 pcLoad", pcLoad, mPhase == 2);
      check(done == (mPhase == 2), "R7 done", done, mPhase == 2);
      if (mPhase == 1) check(int'(ioAddr) == mPort, "R3 ioAddr", ioAddr, mPort);
      if (mPhase == 2) check(int'(pcOut) == mTarget, "R4 pcOut", pcOut, mTarget);
    end
  end

  task automatic doJump(input logic [15:0] addr, input logic [15:0] port,
                        input logic [7:0] b, input int wt, input bit poke);
    int exp;
    string tag;
    exp = (((int'(addr) + 2) % 65536) & 'hC000) + int'(b) * 64;
    if (addr == 16'hBFFF && b == 8'h00) tag = "R5 quarter crossing";
    else if (addr == 16'hFFFF || addr == 16'hFFFD) tag = "R6 wrap/top quarter";
    else if (poke) tag = "R8 busy start ignored";
    else tag = "R4 target";
    @(negedge clk);
    start = 1'b1; instrAddr = addr; portSel = port; respByte = b; waitLimit = wt;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; instrAddr = ~addr; portSel = ~port;
      @(negedge clk);
      start = 1'b0; instrAddr = addr; portSel = port;
    end
    while (!pcLoad) @(negedge clk);
    check(int'(pcOut) == exp, tag, pcOut, exp);
    @(negedge clk);
    check(!ioReq && !pcLoad, "R9 single read", {ioReq, pcLoad}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] addrs [8];
    addrs = '{16'hFFFD, 16'hBFFF, 16'hFFFF, 16'h0000,
              16'h3FFE, 16'h7FFE, 16'h7FFF, 16'h1234};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R5 corner first
    doJump(16'hBFFF, 16'h243B, 8'h00, 0, 1'b0);
    // R3 long wait for the port
    doJump(16'h4000, 16'h243B, 8'hA5, 20, 1'b0);
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 256; b++) begin
        bit pk;
        pk = (b % 16) == 5;
        doJump(addrs[a], {addrs[a][7:0] ^ 8'(b), 8'(b)}, 8'(b),
               pk ? 4 : (b % 4), pk);
      end
    end
    // R8 explicit
    doJump(16'h8123, 16'h1111, 8'h3C, 6, 1'b1);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule